// File: doc/BRIEF.md
# Serial NAND Erase/Program Sequencer

This block sits on the controller side of a serial NAND flash and performs a single array-modifying operation per request. It can erase one block or program one page. The host supplies the operation kind, a page row address, and for a program also a start column, a byte count and a stream of data bytes. The block then drives a byte-wide SPI master handshake with chip-select framing through the full device sequence: write enable, the erase or cache-load command, program execute (program only), and repeated status reads until the device stops reporting busy.

Before it touches the flash, the block shows the target block number to an external bad-block table and samples the answer. A marked block gets no write-enable, erase or load traffic. Any failure (bad block, a device-reported fail bit, or a device still busy after the poll budget is spent) ends with a single write-disable frame. The host is told the outcome by a one-cycle done pulse that carries a 2-bit result code.

Top module: `snand_op_seq`

## Requirements
- R1: During reset and directly after it, `spiCs`, `spiReq`, `doneP` and `dataTake` are low and `reqReady` is high.
- R2: Each operation on a block that is not marked bad opens with a frame holding the single byte 0x06.
- R3: An erase sends the frame 0xD8, A2, A1, A0, where A2..A0 are the three bytes (most significant first) of the row zero-extended to 24 bits with its low PAGE_BITS bits (6 by default) cleared.
- R4: A program sends the frame 0x02, column high, column low, then exactly `reqLen` data bytes. It then sends 0x10, A2, A1, A0, built from the unmodified row.
- R5: Status is read with the frame 0x0F, 0xC0, 0x00, and the byte received during the third byte is the status. A new status frame follows while status bit 0 (busy) is set.
- R6: If bit 0 is still set in the MAX_POLLS-th status byte (100 by default), the block sends one 0x04 frame and reports result 2 (timeout). A device that turns idle exactly on the MAX_POLLS-th read still succeeds.
- R7: When the device turns idle with the fail bit for the operation set, the block sends one 0x04 frame and reports result 1 (device fail). The fail bit is bit 2 for an erase and bit 3 for a program. The fail bit of the other operation is ignored.
- R8: While the block is busy, `bbBlock` shows the row shifted right by PAGE_BITS. If `bbBad` is high for that block, the only frame sent is 0x04 and the result is 3 (bad block).
- R9: A successful operation sends no 0x04 frame and reports result 0.
- R10: `spiCs` is high for the whole of each frame, and it stays low for at least GAP_CLKS clocks between frames.
- R11: `doneP` is high for exactly one clock per accepted request. `reqReady` is high only when the block is idle. A `reqValid` raised while the block is busy is ignored.
- R12: `spiTxByte` holds steady while `spiReq` is high and `spiAck` is low. `dataTake` pulses once for each data byte that is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start request, accepted when `reqReady` is high |
| reqReady | output | 1 | Block is idle |
| reqProgram | input | 1 | 1 = program a page, 0 = erase a block |
| reqRow | input | ROW_W | Page row address |
| reqCol | input | COL_W | Start column for a program |
| reqLen | input | LEN_W | Number of data bytes for a program |
| dataByte | input | 8 | Current program data byte |
| dataTake | output | 1 | `dataByte` was consumed this cycle |
| bbBlock | output | ROW_W-PAGE_BITS | Block number presented to the bad-block table |
| bbBad | input | 1 | Bad-block table answer for `bbBlock` |
| spiCs | output | 1 | Chip select, active high, one frame per assertion |
| spiReq | output | 1 | Byte exchange request |
| spiTxByte | output | 8 | Byte to send |
| spiAck | input | 1 | One-cycle pulse: exchange finished |
| spiRxByte | input | 8 | Received byte, valid with `spiAck` |
| doneP | output | 1 | One-cycle completion pulse |
| doneResult | output | 2 | 0 ok, 1 device fail, 2 timeout, 3 bad block |

## Verification
The assertions rely on a few promises from the inputs. The shifter raises `spiAck` only as a single-cycle pulse while `spiReq` is high, and it starts a new exchange only after the cycle of its previous acknowledge. The host keeps `dataByte` fixed until it sees `dataTake`, and keeps `bbBad` valid for the block on `bbBlock`. The bench's shifter model honours the exchange rule with a fixed two-cycle latency and a forced idle cycle after every acknowledge. Its data source steps only on `dataTake`, and it holds `bbBad` constant for the whole of each request, so none of the checked properties depends on behaviour outside these promises.

// File: rtl/snand_seq_pkg.sv
package snand_seq_pkg;

  localparam logic [7:0] OPC_WR_EN    = 8'h06;
  localparam logic [7:0] OPC_WR_DIS   = 8'h04;
  localparam logic [7:0] OPC_BLK_ERS  = 8'hD8;
  localparam logic [7:0] OPC_LOAD     = 8'h02;
  localparam logic [7:0] OPC_EXEC     = 8'h10;
  localparam logic [7:0] OPC_GET_FEAT = 8'h0F;
  localparam logic [7:0] FEAT_STATUS  = 8'hC0;

  typedef enum logic [2:0] {
    FK_WREN,
    FK_ERASE,
    FK_LOAD,
    FK_EXEC,
    FK_POLL,
    FK_WRDI
  } frameKindE;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_DEVFAIL = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_BADBLK  = 2'd3
  } resultE;

  typedef struct packed {
    logic      latchReq;
    logic      frameGo;
    frameKindE frameKind;
    logic      pollClr;
  } ctrlStrobesT;

endpackage

// File: rtl/snand_seq_dp.sv
module snand_seq_dp
  import snand_seq_pkg::*;
#(
  parameter int ROW_W     = 16,
  parameter int COL_W     = 12,
  parameter int LEN_W     = 12,
  parameter int PAGE_BITS = 6,
  parameter int MAX_POLLS = 100,
  parameter int GAP_CLKS  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobesT                strobes,
  input  logic                       reqProgram,
  input  logic [ROW_W-1:0]           reqRow,
  input  logic [COL_W-1:0]           reqCol,
  input  logic [LEN_W-1:0]           reqLen,
  input  logic [7:0]                 dataByte,
  output logic                       dataTake,
  output logic [ROW_W-PAGE_BITS-1:0] bbBlock,
  output logic                       spiCs,
  output logic                       spiReq,
  output logic [7:0]                 spiTxByte,
  input  logic                       spiAck,
  input  logic [7:0]                 spiRxByte,
  output logic                       frameDone,
  output logic                       opIsProg,
  output logic                       stBusy,
  output logic                       stEraseFail,
  output logic                       stProgFail,
  output logic                       pollLimit
);

  localparam int IDX_W = LEN_W + 2;
  localparam int GC_W  = $clog2(GAP_CLKS + 1);
  localparam int PC_W  = $clog2(MAX_POLLS + 1);

  typedef enum logic [1:0] {E_IDLE, E_SEND, E_GAP} engE;

  engE             eng;
  frameKindE       curKind;
  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [GC_W-1:0]  gapCnt;
  logic [PC_W-1:0]  pollCnt;
  logic             atLast;
  logic             ackInFrame;

  logic [ROW_W-1:0] rowReg;
  logic [COL_W-1:0] colReg;
  logic [LEN_W-1:0] lenReg;
  logic [ROW_W-1:0] rowEff;
  logic [23:0]      row24;
  logic [15:0]      col16;
  logic [2:0]       statBits;
  logic             unusedStatusBits;

  assign unusedStatusBits = ^{spiRxByte[7:4], spiRxByte[1]};

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg   <= '0;
      colReg   <= '0;
      lenReg   <= '0;
      opIsProg <= 1'b0;
    end else if (strobes.latchReq) begin
      rowReg   <= reqRow;
      colReg   <= reqCol;
      lenReg   <= reqLen;
      opIsProg <= reqProgram;
    end
  end

  assign bbBlock = rowReg[ROW_W-1:PAGE_BITS];
  assign rowEff  = opIsProg ? rowReg : {rowReg[ROW_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign row24   = 24'(rowEff);
  assign col16   = 16'(colReg);

  // last byte index of the current frame
  always_comb begin
    case (curKind)
      FK_ERASE, FK_EXEC: lastIdx = IDX_W'(3);
      FK_POLL:           lastIdx = IDX_W'(2);
      FK_LOAD:           lastIdx = IDX_W'(lenReg) + IDX_W'(2);
      default:           lastIdx = '0;
    endcase
  end

  assign atLast     = (byteIdx == lastIdx);
  assign ackInFrame = spiAck && (eng == E_SEND);

  // transmit byte selection
  always_comb begin
    spiTxByte = 8'h00;
    case (curKind)
      FK_WREN:  spiTxByte = OPC_WR_EN;
      FK_WRDI:  spiTxByte = OPC_WR_DIS;
      FK_ERASE, FK_EXEC: begin
        case (byteIdx)
          IDX_W'(0): spiTxByte = (curKind == FK_ERASE) ? OPC_BLK_ERS : OPC_EXEC;
          IDX_W'(1): spiTxByte = row24[23:16];
          IDX_W'(2): spiTxByte = row24[15:8];
          default:   spiTxByte = row24[7:0];
        endcase
      end
      FK_POLL: begin
        case (byteIdx)
          IDX_W'(0): spiTxByte = OPC_GET_FEAT;
          IDX_W'(1): spiTxByte = FEAT_STATUS;
          default:   spiTxByte = 8'h00;
        endcase
      end
      FK_LOAD: begin
        case (byteIdx)
          IDX_W'(0): spiTxByte = OPC_LOAD;
          IDX_W'(1): spiTxByte = col16[15:8];
          IDX_W'(2): spiTxByte = col16[7:0];
          default:   spiTxByte = dataByte;
        endcase
      end
      default: spiTxByte = 8'h00;
    endcase
  end

  assign spiCs    = (eng == E_SEND);
  assign spiReq   = (eng == E_SEND);
  assign dataTake = ackInFrame && (curKind == FK_LOAD) && (byteIdx > IDX_W'(2));

  // frame engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eng       <= E_IDLE;
      curKind   <= FK_WREN;
      byteIdx   <= '0;
      gapCnt    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (eng)
        E_IDLE: begin
          if (strobes.frameGo) begin
            curKind <= strobes.frameKind;
            byteIdx <= '0;
            eng     <= E_SEND;
          end
        end
        E_SEND: begin
          if (spiAck) begin
            if (atLast) begin
              eng    <= E_GAP;
              gapCnt <= '0;
            end else begin
              byteIdx <= byteIdx + IDX_W'(1);
            end
          end
        end
        E_GAP: begin
          if (gapCnt == GC_W'(GAP_CLKS - 1)) begin
            eng       <= E_IDLE;
            frameDone <= 1'b1;
          end else begin
            gapCnt <= gapCnt + GC_W'(1);
          end
        end
        default: eng <= E_IDLE;
      endcase
    end
  end

  // status capture and poll counting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statBits <= '0;
      pollCnt  <= '0;
    end else if (strobes.pollClr) begin
      pollCnt <= '0;
    end else if (ackInFrame && (curKind == FK_POLL) && atLast) begin
      statBits <= {spiRxByte[3], spiRxByte[2], spiRxByte[0]};
      pollCnt  <= pollCnt + PC_W'(1);
    end
  end

  assign stBusy      = statBits[0];
  assign stEraseFail = statBits[1];
  assign stProgFail  = statBits[2];
  assign pollLimit   = (pollCnt >= PC_W'(MAX_POLLS));

  // deselect-time observer for the gap property
  logic [GC_W-1:0] lowCnt;
  always_ff @(posedge clk) begin
    if (!rstN) lowCnt <= GC_W'(GAP_CLKS);
    else if (spiCs) lowCnt <= '0;
    else if (lowCnt != GC_W'(GAP_CLKS)) lowCnt <= lowCnt + GC_W'(1);
  end

  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCs) |-> (lowCnt >= GC_W'(GAP_CLKS)));

  a_r12_tx_stable: assert property (@(posedge clk) disable iff (!rstN)
    (spiReq && !spiAck) |=> (spiReq && $stable(spiTxByte)));

  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= PC_W'(MAX_POLLS));

  a_r12_take_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    dataTake |-> (spiCs && spiAck));

endmodule

// File: rtl/snand_seq_ctrl.sv
module snand_seq_ctrl
  import snand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        bbBad,
  input  logic        frameDone,
  input  logic        opIsProg,
  input  logic        stBusy,
  input  logic        stEraseFail,
  input  logic        stProgFail,
  input  logic        pollLimit,
  output ctrlStrobesT strobes,
  output logic        doneP,
  output logic [1:0]  doneResult
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_WREN, S_CMD, S_EXEC, S_POLL, S_WRDI, S_DONE
  } stateE;

  stateE  state, stateNext;
  resultE resReg, resNext;
  logic   badSeen;
  logic   failBit;

  assign failBit = opIsProg ? stProgFail : stEraseFail;

  always_comb begin
    stateNext         = state;
    resNext           = resReg;
    strobes           = '0;
    strobes.frameKind = FK_WREN;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobes.latchReq = 1'b1;
          stateNext        = S_CHK;
        end
      end
      S_CHK: begin
        strobes.frameGo = 1'b1;
        if (bbBad) begin
          strobes.frameKind = FK_WRDI;
          resNext           = RES_BADBLK;
          stateNext         = S_WRDI;
        end else begin
          strobes.frameKind = FK_WREN;
          stateNext         = S_WREN;
        end
      end
      S_WREN: begin
        if (frameDone) begin
          strobes.frameGo   = 1'b1;
          strobes.frameKind = opIsProg ? FK_LOAD : FK_ERASE;
          stateNext         = S_CMD;
        end
      end
      S_CMD: begin
        if (frameDone) begin
          strobes.frameGo = 1'b1;
          if (opIsProg) begin
            strobes.frameKind = FK_EXEC;
            stateNext         = S_EXEC;
          end else begin
            strobes.pollClr   = 1'b1;
            strobes.frameKind = FK_POLL;
            stateNext         = S_POLL;
          end
        end
      end
      S_EXEC: begin
        if (frameDone) begin
          strobes.frameGo   = 1'b1;
          strobes.pollClr   = 1'b1;
          strobes.frameKind = FK_POLL;
          stateNext         = S_POLL;
        end
      end
      S_POLL: begin
        if (frameDone) begin
          if (stBusy) begin
            strobes.frameGo = 1'b1;
            if (pollLimit) begin
              strobes.frameKind = FK_WRDI;
              resNext           = RES_TIMEOUT;
              stateNext         = S_WRDI;
            end else begin
              strobes.frameKind = FK_POLL;
            end
          end else if (failBit) begin
            strobes.frameGo   = 1'b1;
            strobes.frameKind = FK_WRDI;
            resNext           = RES_DEVFAIL;
            stateNext         = S_WRDI;
          end else begin
            resNext   = RES_OK;
            stateNext = S_DONE;
          end
        end
      end
      S_WRDI: begin
        if (frameDone) stateNext = S_DONE;
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      resReg  <= RES_OK;
      badSeen <= 1'b0;
    end else begin
      state  <= stateNext;
      resReg <= resNext;
      if (state == S_IDLE) badSeen <= 1'b0;
      else if (state == S_CHK && bbBad) badSeen <= 1'b1;
    end
  end

  assign reqReady   = (state == S_IDLE);
  assign doneP      = (state == S_DONE);
  assign doneResult = resReg;

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  a_r8_bad_only_wrdi: assert property (@(posedge clk) disable iff (!rstN)
    (badSeen && strobes.frameGo) |-> (strobes.frameKind == FK_WRDI));

  a_r8_bad_result: assert property (@(posedge clk) disable iff (!rstN)
    (badSeen && doneP) |-> (doneResult == RES_BADBLK));

  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady) |-> !strobes.latchReq);

endmodule

// File: rtl/snand_op_seq.sv
module snand_op_seq
  import snand_seq_pkg::*;
#(
  parameter int ROW_W     = 16,
  parameter int COL_W     = 12,
  parameter int LEN_W     = 12,
  parameter int PAGE_BITS = 6,
  parameter int MAX_POLLS = 100,
  parameter int GAP_CLKS  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic                       reqProgram,
  input  logic [ROW_W-1:0]           reqRow,
  input  logic [COL_W-1:0]           reqCol,
  input  logic [LEN_W-1:0]           reqLen,
  input  logic [7:0]                 dataByte,
  output logic                       dataTake,
  output logic [ROW_W-PAGE_BITS-1:0] bbBlock,
  input  logic                       bbBad,
  output logic                       spiCs,
  output logic                       spiReq,
  output logic [7:0]                 spiTxByte,
  input  logic                       spiAck,
  input  logic [7:0]                 spiRxByte,
  output logic                       doneP,
  output logic [1:0]                 doneResult
);

  ctrlStrobesT strobes;
  logic frameDone, opIsProg, stBusy, stEraseFail, stProgFail, pollLimit;

  snand_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .bbBad      (bbBad),
    .frameDone  (frameDone),
    .opIsProg   (opIsProg),
    .stBusy     (stBusy),
    .stEraseFail(stEraseFail),
    .stProgFail (stProgFail),
    .pollLimit  (pollLimit),
    .strobes    (strobes),
    .doneP      (doneP),
    .doneResult (doneResult)
  );

  snand_seq_dp #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .LEN_W    (LEN_W),
    .PAGE_BITS(PAGE_BITS),
    .MAX_POLLS(MAX_POLLS),
    .GAP_CLKS (GAP_CLKS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqProgram (reqProgram),
    .reqRow     (reqRow),
    .reqCol     (reqCol),
    .reqLen     (reqLen),
    .dataByte   (dataByte),
    .dataTake   (dataTake),
    .bbBlock    (bbBlock),
    .spiCs      (spiCs),
    .spiReq     (spiReq),
    .spiTxByte  (spiTxByte),
    .spiAck     (spiAck),
    .spiRxByte  (spiRxByte),
    .frameDone  (frameDone),
    .opIsProg   (opIsProg),
    .stBusy     (stBusy),
    .stEraseFail(stEraseFail),
    .stProgFail (stProgFail),
    .pollLimit  (pollLimit)
  );

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!spiCs && !spiReq));

  a_r10_req_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    spiReq |-> spiCs);

endmodule

// File: tb/snand_op_seq_test.sv
module snand_op_seq_test;

  localparam int ROW_W = 16, COL_W = 12, LEN_W = 12, PAGE_BITS = 6;
  localparam int MAX_POLLS = 100, GAP_CLKS = 2, LAT = 2;

  typedef struct packed {
    logic        prog;
    logic [15:0] row;
    logic [15:0] col;
    logic [11:0] len;
    logic        bad;
    logic [7:0]  busy;
    logic [7:0]  stat;
    logic [1:0]  expRes;
  } vecT;

  localparam int NV = 11;
  localparam vecT VECS [NV] = '{
    '{1'b0, 16'h1234, 16'h0000, 12'd0, 1'b0, 8'd3,   8'h00, 2'd0},
    '{1'b0, 16'h0040, 16'h0000, 12'd0, 1'b0, 8'd0,   8'h08, 2'd0},
    '{1'b0, 16'h03C5, 16'h0000, 12'd0, 1'b0, 8'd1,   8'h04, 2'd1},
    '{1'b1, 16'h0457, 16'h0123, 12'd5, 1'b0, 8'd2,   8'h00, 2'd0},
    '{1'b1, 16'h0001, 16'h07FE, 12'd3, 1'b0, 8'd0,   8'h08, 2'd1},
    '{1'b1, 16'h0802, 16'h0000, 12'd2, 1'b0, 8'd4,   8'h04, 2'd0},
    '{1'b0, 16'h0FC0, 16'h0000, 12'd0, 1'b1, 8'd0,   8'h00, 2'd3},
    '{1'b1, 16'h0ABC, 16'h0010, 12'd4, 1'b1, 8'd0,   8'h00, 2'd3},
    '{1'b0, 16'h2000, 16'h0000, 12'd0, 1'b0, 8'd150, 8'h00, 2'd2},
    '{1'b1, 16'h0005, 16'h0010, 12'd1, 1'b0, 8'd99,  8'h00, 2'd0},
    '{1'b1, 16'h0006, 16'h0020, 12'd1, 1'b0, 8'd100, 8'h00, 2'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqProgram = 1'b0, bbBad = 1'b0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [7:0] dataByte;
  logic dataTake, reqReady, spiCs, spiReq, spiAck, doneP;
  logic [ROW_W-PAGE_BITS-1:0] bbBlock;
  logic [7:0] spiTxByte, spiRxByte;
  logic [1:0] doneResult;

  always #4 clk = ~clk;

  snand_op_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS),
                 .MAX_POLLS(MAX_POLLS), .GAP_CLKS(GAP_CLKS)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqProgram(reqProgram), .reqRow(reqRow), .reqCol(reqCol), .reqLen(reqLen),
    .dataByte(dataByte), .dataTake(dataTake), .bbBlock(bbBlock), .bbBad(bbBad),
    .spiCs(spiCs), .spiReq(spiReq), .spiTxByte(spiTxByte), .spiAck(spiAck),
    .spiRxByte(spiRxByte), .doneP(doneP), .doneResult(doneResult));

  // configuration of the device model, written by the stimulus only
  int cfgBase = 0, cfgBusy = 0;
  logic [7:0] cfgFinal = 8'h00;

  // device / shifter model and byte log
  logic [7:0] logB [4096];
  logic       logF [4096];
  int nLog = 0, served = 0, mPos = 0, mCnt = 0, takes = 0, dones = 0;
  int lowRun = 0, minGap = 1000;
  logic mBusy = 1'b0, seenFrame = 1'b0;
  logic [7:0] mTx = 8'h00, mRx = 8'h00, mHead = 8'h00;
  logic [7:0] dataCnt = 8'h00;

  assign dataByte = 8'hA0 + dataCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      spiAck <= 1'b0;
      spiRxByte <= 8'h00;
      mBusy = 1'b0;
      mPos = 0;
    end else begin
      spiAck <= 1'b0;
      if (!spiCs) mPos = 0;
      if (mBusy) begin
        if (mCnt == 0) begin
          spiAck <= 1'b1;
          spiRxByte <= mRx;
          mBusy = 1'b0;
          if (nLog < 4096) begin
            logB[nLog] = mTx;
            logF[nLog] = (mPos == 0);
            nLog++;
          end
          if (mPos == 0) mHead = mTx;
          mPos++;
        end else mCnt--;
      end else if (spiCs && spiReq && !spiAck) begin
        mBusy = 1'b1;
        mCnt = LAT;
        mTx = spiTxByte;
        if (mPos == 2 && mHead == 8'h0F) begin
          mRx = ((served - cfgBase) < cfgBusy) ? 8'h01 : cfgFinal;
          served++;
        end else mRx = 8'hFF;
      end
    end
  end

  always @(posedge clk) begin
    if (dataTake) begin
      dataCnt <= dataCnt + 8'd1;
      takes++;
    end
    if (doneP) dones++;
    if (spiCs) begin
      if (seenFrame && lowRun > 0 && lowRun < minGap) minGap = lowRun;
      lowRun = 0;
      seenFrame = 1'b1;
    end else lowRun++;
  end

  int nChecks = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [7:0] expB [4096];
  logic       expF [4096];
  int nExp;

  task automatic pushB(input logic [7:0] b, input logic f);
    expB[nExp] = b;
    expF[nExp] = f;
    nExp++;
  endtask

  task automatic runOp(input vecT v, input bit stray);
    int base, dStart, tStart, dStartCnt, polls, got, seen, mism, mIdx, frA, frE;
    logic [23:0] r24;
    logic [15:0] c16;
    string tag;
    bit timeoutCase, failCase;
    nExp = 0;
    base = nLog;
    dStart = int'(dataCnt);
    tStart = takes;
    dStartCnt = dones;
    timeoutCase = (int'(v.busy) >= MAX_POLLS);
    failCase = v.prog ? v.stat[3] : v.stat[2];
    // expected byte stream from the requirements
    if (v.bad) pushB(8'h04, 1'b1);
    else begin
      pushB(8'h06, 1'b1);
      if (!v.prog) begin
        r24 = {8'h00, v.row[15:6], 6'b0};
        pushB(8'hD8, 1'b1); pushB(r24[23:16], 1'b0); pushB(r24[15:8], 1'b0); pushB(r24[7:0], 1'b0);
      end else begin
        c16 = v.col;
        r24 = {8'h00, v.row};
        pushB(8'h02, 1'b1); pushB(c16[15:8], 1'b0); pushB(c16[7:0], 1'b0);
        for (int i = 0; i < int'(v.len); i++) pushB(8'hA0 + 8'(dStart + i), 1'b0);
        pushB(8'h10, 1'b1); pushB(r24[23:16], 1'b0); pushB(r24[15:8], 1'b0); pushB(r24[7:0], 1'b0);
      end
      polls = timeoutCase ? MAX_POLLS : int'(v.busy) + 1;
      for (int p = 0; p < polls; p++) begin
        pushB(8'h0F, 1'b1); pushB(8'hC0, 1'b0); pushB(8'h00, 1'b0);
      end
      if (timeoutCase || failCase) pushB(8'h04, 1'b1);
    end
    if (v.bad) tag = "R8";
    else if (timeoutCase) tag = "R6";
    else if (failCase) tag = "R7";
    else tag = "R9";

    @(negedge clk);
    cfgBase = served;
    cfgBusy = int'(v.busy);
    cfgFinal = v.stat;
    reqProgram = v.prog;
    reqRow = v.row;
    reqCol = v.col[COL_W-1:0];
    reqLen = v.len;
    bbBad = v.bad;
    check(reqReady == 1'b1, "R11", "ready before request", reqReady, 1);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(bbBlock == v.row[15:6], "R8", "bbBlock", bbBlock, v.row[15:6]);
    check(reqReady == 1'b0, "R11", "ready while busy", reqReady, 0);
    got = 0;
    seen = 0;
    for (int c = 0; c < 20000 && seen == 0; c++) begin
      if (stray && c >= 20 && c < 24) begin
        reqValid = 1'b1;
        reqProgram = ~v.prog;
      end else reqValid = 1'b0;
      @(negedge clk);
      if (doneP) begin
        seen = 1;
        got = int'(doneResult);
      end
    end
    reqValid = 1'b0;
    check(seen == 1, "R11", "done seen", seen, 1);
    check(got == int'(v.expRes), tag, "result", got, v.expRes);
    @(negedge clk);
    check(doneP == 1'b0, "R11", "done width", doneP, 0);
    check(dones - dStartCnt == 1, "R11", "done count", dones - dStartCnt, 1);
    check(nLog - base == nExp, v.prog ? "R4" : "R3", "byte count", nLog - base, nExp);
    mism = 0; mIdx = 0; frA = 0; frE = 0;
    for (int i = 0; i < nExp && i < nLog - base; i++) begin
      if (logB[base+i] != expB[i] && mism == 0) begin mism = 1; mIdx = i; end
      if (logF[base+i]) frA++;
      if (expF[i]) frE++;
    end
    check(mism == 0, v.prog ? "R4/R5" : "R3/R5", "byte stream",
          mism ? logB[base+mIdx] : 0, mism ? expB[mIdx] : 0);
    check(frA == frE, "R10", "frame count", frA, frE);
    if (!v.bad)
      check(logB[base] == 8'h06 && logF[base], "R2", "opening write enable", logB[base], 8'h06);
    check(takes - tStart == (v.prog && !v.bad ? int'(v.len) : 0), "R12", "data takes",
          takes - tStart, (v.prog && !v.bad) ? v.len : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(spiCs == 0 && spiReq == 0 && doneP == 0 && dataTake == 0, "R1", "outputs in reset",
          {spiCs, spiReq, doneP, dataTake}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && spiCs == 1'b0, "R1", "idle after reset", {reqReady, spiCs}, 2'b10);
    for (int k = 0; k < NV; k++) runOp(VECS[k], 1'b0);
    // request raised while busy is ignored
    runOp('{1'b0, 16'h0100, 16'h0000, 12'd0, 1'b0, 8'd5, 8'h00, 2'd0}, 1'b1);
    check(minGap >= GAP_CLKS, "R10", "minimum deselect", minGap, GAP_CLKS);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule